// File: doc/BRIEF.md
# Page Hamming ECC Accumulator

This block watches the byte stream that moves between a NAND flash device and its controller. It builds a single-error-correcting Hamming code over every 512-byte chunk of page data. The same path serves page reads and page writes. Each chunk gives a 24-bit code made of two 12-bit halves. The lower half is the odd parity set and the upper half is the even parity set. In each half, bits [11:3] hold a byte position inside the chunk and bits [2:0] hold a bit position inside that byte.

A two-bit size select sets the page length to one, two or four chunks. A last flag on the final byte closes the page. The block then spends a few cycles moving the per-chunk codes into four 32-bit result words, one chunk at a time, and holds a busy flag high while it does so. Software waits for busy to fall and then reads the words. Each word carries the code in its low 24 bits and a status byte above it. Status bit 6 marks a chunk whose 512 bytes were all absorbed.

Top module: `nand_page_ecc`

## Requirements
- R1: For every set bit of a byte at chunk offset i (0..511), bit b (0..7), the odd half (word bits [11:0]) is XORed with the 12-bit value i*8+b, and the even half (word bits [23:12]) is XORed with the bitwise complement of that value.
- R2: Each 512-byte chunk is coded on its own, starting from zero. The code of chunk k appears in result word k, which is bits [32k+31:32k] of `ecc_words_o`.
- R3: Status bit 6 of a result word (word bit 30) is 1 exactly when that chunk received all 512 bytes. All other status bits read 0.
- R4: The size select is sampled on the first byte of a page: 3 gives 4 chunks, 2 gives 2 chunks, 1 or 0 gives 1 chunk. Changes to the select later in the page have no effect.
- R5: Bytes that arrive after the configured page length has been reached, and before the last flag, change no result word.
- R6: A result word for a chunk that was cut short by the last flag, or that lies beyond the configured page size, reads as all zeros.
- R7: `busy_o` is 0 after reset. It goes to 1 in the cycle after the last byte is accepted and stays 1 for exactly 4 cycles. When it falls, all result words hold the finished page, and they keep those values until the next page starts.
- R8: The first byte accepted for a new page clears every result word to zero by the next cycle.
- R9: Bytes offered while `busy_o` is 1, including ones carrying the last flag, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_size_i | input | 2 | Page size select (0/1: 512 B, 2: 1024 B, 3: 2048 B) |
| byte_valid_i | input | 1 | A data byte is present this cycle |
| byte_data_i | input | 8 | Page data byte |
| byte_last_i | input | 1 | Marks the final byte of the page |
| ecc_words_o | output | 128 | Four result words; word k is bits [32k+31:32k] |
| busy_o | output | 1 | High while codes are being finalized |

## Verification
The bench aims at these corner cases:
- A single flipped bit at a known offset. An index or complement mistake then shows up as a wrong odd or even half.
- A full 2048-byte page. A design that fails to restart the accumulator at each chunk boundary leaks one chunk's code into the next.
- A page cut short inside a chunk, and a page that overruns its configured length. A faulty design either marks the cut chunk valid or lets the extra bytes alter a code.
- A size select changed in mid-page, junk bytes (some with the last flag) offered while busy, and a check that the words are zero just after a new page begins. A stale or ungated design shows the old page, starts a false page, or keeps busy high for the wrong number of cycles.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DEF_CHUNK_BYTES = 512;
    localparam int DEF_MAX_CHUNKS  = 4;
    localparam int DEF_DATA_W      = 8;
    localparam int DEF_WORD_W      = 32;
    localparam int DEF_VALID_BIT   = 30;

    localparam logic [1:0] SEL_ONE_CHUNK  = 2'd1;
    localparam logic [1:0] SEL_TWO_CHUNK  = 2'd2;
    localparam logic [1:0] SEL_FOUR_CHUNK = 2'd3;

    typedef enum logic {
        PUB_IDLE = 1'b0,
        PUB_RUN  = 1'b1
    } pub_state_e;

    typedef struct packed {
        logic       take;
        logic       start;
        logic       done;
    } beat_ctl_t;

    function automatic int chunks_for_sel(input logic [1:0] sel, input int max_chunks);
        int n;
        case (sel)
            SEL_FOUR_CHUNK: n = 4;
            SEL_TWO_CHUNK:  n = 2;
            default:        n = 1;
        endcase
        if (n > max_chunks) n = max_chunks;
        return n;
    endfunction

endpackage

// File: rtl/ecc_chunk_accum.sv
module ecc_chunk_accum
    import ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = DEF_CHUNK_BYTES,
    parameter int MAX_CHUNKS  = DEF_MAX_CHUNKS,
    parameter int DATA_W      = DEF_DATA_W,
    localparam int IDX_W      = $clog2(CHUNK_BYTES),
    localparam int BIT_W      = $clog2(DATA_W),
    localparam int HALF_W     = IDX_W + BIT_W,
    localparam int CODE_W     = 2 * HALF_W,
    localparam int CHK_W      = $clog2(MAX_CHUNKS),
    localparam int CNT_W      = IDX_W + CHK_W + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept_i,
    input  logic                         last_i,
    input  logic [DATA_W-1:0]            data_i,
    input  logic [1:0]                   size_sel_i,
    output logic                         page_start_o,
    output logic                         page_done_o,
    output logic [MAX_CHUNKS*CODE_W-1:0] stage_code_o,
    output logic [MAX_CHUNKS-1:0]        stage_valid_o
);

    logic                in_page_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    limit_q;
    logic [CODE_W-1:0]   acc_q;
    logic [CODE_W-1:0]   stage_q [MAX_CHUNKS];
    logic [MAX_CHUNKS-1:0] stage_valid_q;

    beat_ctl_t           ctl;
    logic [CNT_W-1:0]    cur_limit;
    logic [CNT_W-1:0]    cnt_base;
    logic [CODE_W-1:0]   acc_base;
    logic [CODE_W-1:0]   acc_next;
    logic [IDX_W-1:0]    idx;
    logic [CHK_W-1:0]    chunk;
    logic                chunk_end;
    logic [HALF_W-1:0]   odd_x;
    logic [HALF_W-1:0]   even_x;

    function automatic logic [CNT_W-1:0] limit_of(input logic [1:0] sel);
        return CNT_W'(chunks_for_sel(sel, MAX_CHUNKS) * CHUNK_BYTES);
    endfunction

    always_comb begin
        ctl.start = accept_i && !in_page_q;
        ctl.done  = accept_i && last_i;
        cur_limit = ctl.start ? limit_of(size_sel_i) : limit_q;
        cnt_base  = ctl.start ? '0 : cnt_q;
        acc_base  = ctl.start ? '0 : acc_q;
        ctl.take  = accept_i && (cnt_base < cur_limit);
        idx       = cnt_base[IDX_W-1:0];
        chunk     = cnt_base[IDX_W +: CHK_W];
        chunk_end = ctl.take && (idx == IDX_W'(CHUNK_BYTES - 1));
    end

    // Line/column parity contribution of one byte
    always_comb begin
        logic [HALF_W-1:0] pos;
        odd_x  = '0;
        even_x = '0;
        for (int b = 0; b < DATA_W; b++) begin
            pos = {idx, BIT_W'(b)};
            if (data_i[b]) begin
                odd_x  = odd_x ^ pos;
                even_x = even_x ^ ~pos;
            end
        end
        acc_next = acc_base ^ {even_x, odd_x};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_page_q     <= 1'b0;
            cnt_q         <= '0;
            limit_q       <= '0;
            acc_q         <= '0;
            stage_valid_q <= '0;
            for (int k = 0; k < MAX_CHUNKS; k++) stage_q[k] <= '0;
        end else begin
            if (ctl.start) begin
                limit_q       <= cur_limit;
                stage_valid_q <= '0;
                for (int k = 0; k < MAX_CHUNKS; k++) stage_q[k] <= '0;
            end
            if (accept_i) in_page_q <= !last_i;
            if (ctl.take) begin
                cnt_q <= cnt_base + 1'b1;
                acc_q <= chunk_end ? '0 : acc_next;
                if (chunk_end) begin
                    stage_q[chunk]       <= acc_next;
                    stage_valid_q[chunk] <= 1'b1;
                end
            end else if (ctl.start) begin
                cnt_q <= '0;
                acc_q <= '0;
            end
        end
    end

    assign page_start_o  = ctl.start;
    assign page_done_o   = ctl.done;
    assign stage_valid_o = stage_valid_q;

    for (genvar k = 0; k < MAX_CHUNKS; k++) begin : g_flat
        assign stage_code_o[k*CODE_W +: CODE_W] = stage_q[k];

        // R3
        chunk_full_chk: assert property (@(posedge clk) disable iff (rst)
            stage_valid_q[k] |-> (cnt_q >= CNT_W'((k + 1) * CHUNK_BYTES)));
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_page_q |-> (cnt_q <= limit_q));

endmodule

// File: rtl/ecc_result_publish.sv
module ecc_result_publish
    import ecc_pkg::*;
#(
    parameter int MAX_CHUNKS = DEF_MAX_CHUNKS,
    parameter int CODE_W     = 24,
    parameter int WORD_W     = DEF_WORD_W,
    parameter int VALID_BIT  = DEF_VALID_BIT,
    localparam int CHK_W     = $clog2(MAX_CHUNKS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         page_start_i,
    input  logic                         page_done_i,
    input  logic [MAX_CHUNKS*CODE_W-1:0] stage_code_i,
    input  logic [MAX_CHUNKS-1:0]        stage_valid_i,
    output logic [MAX_CHUNKS*WORD_W-1:0] words_o,
    output logic                         busy_o
);

    pub_state_e          state_q;
    logic [CHK_W-1:0]    ptr_q;
    logic [WORD_W-1:0]   words_q [MAX_CHUNKS];
    logic [WORD_W-1:0]   packed_word;

    always_comb begin
        packed_word            = '0;
        packed_word[CODE_W-1:0] = stage_code_i[ptr_q*CODE_W +: CODE_W];
        packed_word[VALID_BIT] = stage_valid_i[ptr_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PUB_IDLE;
            ptr_q   <= '0;
            for (int k = 0; k < MAX_CHUNKS; k++) words_q[k] <= '0;
        end else begin
            if (page_start_i) begin
                for (int k = 0; k < MAX_CHUNKS; k++) words_q[k] <= '0;
            end
            if (page_done_i) begin
                state_q <= PUB_RUN;
                ptr_q   <= '0;
            end else if (state_q == PUB_RUN) begin
                words_q[ptr_q] <= packed_word;
                ptr_q          <= ptr_q + 1'b1;
                if (ptr_q == CHK_W'(MAX_CHUNKS - 1)) state_q <= PUB_IDLE;
            end
        end
    end

    assign busy_o = (state_q == PUB_RUN);

    for (genvar k = 0; k < MAX_CHUNKS; k++) begin : g_out
        assign words_o[k*WORD_W +: WORD_W] = words_q[k];
    end

    // R7
    done_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
        page_done_i |=> busy_o);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> ($past(ptr_q) == CHK_W'(MAX_CHUNKS - 1)));

    // R8
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        page_start_i |=> (words_o == '0));

    // R9
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !(page_start_i || page_done_i));

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
    import ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = DEF_CHUNK_BYTES,
    parameter int MAX_CHUNKS  = DEF_MAX_CHUNKS,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int WORD_W      = DEF_WORD_W,
    parameter int VALID_BIT   = DEF_VALID_BIT,
    localparam int CODE_W     = 2 * ($clog2(CHUNK_BYTES) + $clog2(DATA_W))
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   page_size_i,
    input  logic                         byte_valid_i,
    input  logic [DATA_W-1:0]            byte_data_i,
    input  logic                         byte_last_i,
    output logic [MAX_CHUNKS*WORD_W-1:0] ecc_words_o,
    output logic                         busy_o
);

    logic                         accept;
    logic                         page_start;
    logic                         page_done;
    logic [MAX_CHUNKS*CODE_W-1:0] stage_code;
    logic [MAX_CHUNKS-1:0]        stage_valid;

    assign accept = byte_valid_i && !busy_o;

    ecc_chunk_accum #(
        .CHUNK_BYTES (CHUNK_BYTES),
        .MAX_CHUNKS  (MAX_CHUNKS),
        .DATA_W      (DATA_W)
    ) u_accum (
        .clk           (clk),
        .rst           (rst),
        .accept_i      (accept),
        .last_i        (byte_last_i),
        .data_i        (byte_data_i),
        .size_sel_i    (page_size_i),
        .page_start_o  (page_start),
        .page_done_o   (page_done),
        .stage_code_o  (stage_code),
        .stage_valid_o (stage_valid)
    );

    ecc_result_publish #(
        .MAX_CHUNKS (MAX_CHUNKS),
        .CODE_W     (CODE_W),
        .WORD_W     (WORD_W),
        .VALID_BIT  (VALID_BIT)
    ) u_publish (
        .clk           (clk),
        .rst           (rst),
        .page_start_i  (page_start),
        .page_done_i   (page_done),
        .stage_code_i  (stage_code),
        .stage_valid_i (stage_valid),
        .words_o       (ecc_words_o),
        .busy_o        (busy_o)
    );

endmodule

// File: tb/tb_nand_page_ecc.sv
module tb_nand_page_ecc;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   page_size_i = 2'd1;
    logic         byte_valid_i = 1'b0;
    logic [7:0]   byte_data_i = 8'h00;
    logic         byte_last_i = 1'b0;
    logic [127:0] ecc_words_o;
    logic         busy_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] pg [0:2599];

    always #10 clk = ~clk;

    nand_page_ecc dut (
        .clk          (clk),
        .rst          (rst),
        .page_size_i  (page_size_i),
        .byte_valid_i (byte_valid_i),
        .byte_data_i  (byte_data_i),
        .byte_last_i  (byte_last_i),
        .ecc_words_o  (ecc_words_o),
        .busy_o       (busy_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k, input int n, input int sel);
        int nch;
        int eff;
        logic [11:0] odd;
        logic [11:0] even;
        logic [11:0] v;
        nch = (sel == 3) ? 4 : (sel == 2) ? 2 : 1;
        eff = (n < nch * 512) ? n : nch * 512;
        if (k >= nch || eff < (k + 1) * 512) return 32'h0;
        odd  = '0;
        even = '0;
        for (int i = 0; i < 512; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (pg[k*512 + i][b]) begin
                    v    = 12'(i * 8 + b);
                    odd  = odd ^ v;
                    even = even ^ ~v;
                end
            end
        end
        return {1'b0, 1'b1, 6'b0, even, odd};
    endfunction

    task automatic send_page(input int n, input int sel0, input int sw_at,
                             input int sel1, input bit junk, input string tag);
        int cyc;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 1) begin
                for (int k = 0; k < 4; k++)
                    chk(ecc_words_o[k*32 +: 32], 32'h0, "R8 cleared at page start");
            end
            if (i == 0) page_size_i = 2'(sel0);
            if (i == sw_at) page_size_i = 2'(sel1);
            byte_valid_i = 1'b1;
            byte_data_i  = pg[i];
            byte_last_i  = (i == n - 1);
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
        byte_last_i  = 1'b0;
        chk({31'b0, busy_o}, 32'd1, "R7 busy after last");
        cyc = 0;
        while (busy_o === 1'b1 && cyc < 20) begin
            cyc++;
            if (junk) begin
                byte_valid_i = 1'b1;
                byte_data_i  = 8'($urandom);
                byte_last_i  = 1'($urandom);
            end
            @(negedge clk);
        end
        byte_valid_i = 1'b0;
        byte_last_i  = 1'b0;
        chk(32'(cyc), 32'd4, "R7 busy length");
        for (int k = 0; k < 4; k++)
            chk(ecc_words_o[k*32 +: 32], exp_word(k, n, sel0), tag);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++)
            chk(ecc_words_o[k*32 +: 32], exp_word(k, n, sel0), "R7 words held");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        int s;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({31'b0, busy_o}, 32'd0, "R7 reset busy");
        for (int k = 0; k < 4; k++)
            chk(ecc_words_o[k*32 +: 32], 32'h0, "R8 reset words");

        // R3: all-zero chunk gives valid status and zero code
        for (int i = 0; i < 2600; i++) pg[i] = 8'h00;
        send_page(512, 1, -1, 1, 1'b0, "R3 zero chunk");

        // R1: single bit at offset 300 bit 5 -> odd 965, even 69A
        pg[300] = 8'h20;
        send_page(512, 1, -1, 1, 1'b0, "R1 single bit");
        chk(ecc_words_o[31:0], 32'h4069A965, "R1 single bit literal");
        pg[300] = 8'h00;

        // R2 + R9: full four-chunk page with junk offered while busy
        for (int i = 0; i < 2600; i++) pg[i] = 8'($urandom);
        send_page(2048, 3, -1, 3, 1'b1, "R2 four chunks");

        // R6: page cut inside second chunk
        send_page(700, 2, -1, 2, 1'b0, "R6 partial chunk");

        // R5: overrun past one-chunk page
        send_page(600, 1, -1, 1, 1'b1, "R5 overrun ignored");

        // R4: select changed mid-page has no effect
        send_page(2048, 3, 100, 1, 1'b0, "R4 mid-page select change");

        // R4: select 0 acts as one chunk
        send_page(1024, 0, -1, 0, 1'b0, "R4 select zero");

        // random pages
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 2600; i++) pg[i] = 8'($urandom);
            n = 2 + int'($urandom % 2099);
            s = int'($urandom % 4);
            send_page(n, s, -1, s, 1'($urandom), "R2 R6 random page");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule